// File: doc/BRIEF.md
# Trigger-Positioned Trace Capture Buffer

This block records a stream of sample words (for example a bus address, data and status bits packed into one word) into an on-chip circular store. After an acquisition is armed, every stored sample goes to the next location, and the write position wraps at the end of the store. A trigger ends the acquisition after a programmed amount of post-trigger history. The split between history before and after the trigger is set in steps of 1/512 of the depth, so the frozen buffer holds the context around the event.

Two store modes decide which cycles count. In the every-cycle mode, each clock cycle while capturing is stored. In the transfer mode, only cycles flagged as valid transfers are stored. Trace control comes from the trigger logic as three commands. A single command arms one triggered acquisition that halts by itself. A start command begins free recording that ignores triggers. A stop command halts either kind at once.

After capture halts, the reader uses the latched trigger address and the count of valid pre-trigger entries to upload the buffer through a synchronous read port, starting from the oldest valid entry. Samples arrive on a valid/ready pair. `s_ready` is high exactly while capture is active, and a sample is taken on any cycle where the mode qualifies it while `s_ready` is high. There is no back-pressure during capture: the producer never has to stall. When `s_ready` is low, samples are dropped. Samples are also dropped in a cycle that carries a command.

Top module: `trace_buf`

## Requirements
- R1: After reset, `done`, `s_ready` and `rd_err` are 0.
- R2: A single command arms capture: `s_ready` goes to 1 and `done` to 0 in the next cycle. After the trigger sample, exactly P = floor(DEPTH*(512-q)/512) further samples are stored. Here q is `trig_pos` taken at arming, and a value of 0 counts as 1. In the cycle after the last of them, `done`=1 and `s_ready`=0.
- R3: A trigger counts only in a cycle whose sample is stored. A trigger in an unqualified cycle is ignored. `trig_addr` gives the address where the trigger sample was written.
- R4: `pre_cnt` = min(number of samples stored before the trigger, DEPTH-1-P). It is valid once `s_ready` has fallen.
- R5: With `store_all`=1 (taken at arming), every cycle with `s_ready`=1 is stored, whatever the value of `s_valid`. With `store_all`=0, only cycles with `s_valid`=1 are stored.
- R6: Arming resets the write address to 0. Each stored sample then goes to the current address, which then advances by one modulo DEPTH. The n-th stored sample (counting from 0) is therefore at address n mod DEPTH.
- R7: A read (`rd_en`=1) while `s_ready`=0 returns the stored word at `rd_addr` on `rd_data` one cycle later, with `rd_err`=0. A read while `s_ready`=1 returns 0 with `rd_err`=1 one cycle later.
- R8: A start command begins free recording, in which triggers are ignored. A following stop halts it with `done`=0. After n≥1 stored samples, `trig_addr` = (n-1) mod DEPTH and `pre_cnt` = min(n,DEPTH)-1.
- R9: Stop has priority over start and single, and single has priority over start. A stop during a triggered acquisition halts it with `done`=0.
- R10: Once capture has halted, further samples and triggers leave the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | Begin free recording (triggers ignored) |
| cmd_single | input | 1 | Arm one triggered acquisition |
| cmd_stop | input | 1 | Halt capture now |
| store_all | input | 1 | 1: store every cycle, 0: store only valid transfers |
| trig_pos | input | 9 | Trigger position in 1/512 steps of the depth |
| trig | input | 1 | Trigger pulse |
| s_valid | input | 1 | Sample is a valid transfer |
| s_data | input | DATA_W | Sample word |
| s_ready | output | 1 | Capture active; samples are accepted |
| done | output | 1 | Triggered acquisition completed |
| trig_addr | output | ADDR_W | Address of trigger sample (or last sample after a stop of free recording) |
| pre_cnt | output | ADDR_W | Number of valid entries before `trig_addr` |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, one cycle after the request |
| rd_err | output | 1 | Read was refused because capture was active |

## Verification
The bench builds the block with ADDR_W=5 (32 entries) and DATA_W=8. At this size every one of the 512 trigger positions can be swept, each with its own trigger moment. That brings post lengths from 0 to 31 within reach, as well as pre-trigger regions that are either full or only partly written. Every stored entry of each acquisition is read back and compared against the sample numbering, alternating between the two store modes. The small depth also lets free recording wrap the buffer more than once within a few dozen samples.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int POS_W     = 9;
  localparam int POS_STEPS = 1 << POS_W;

  typedef enum logic [2:0] {
    CAP_IDLE,
    CAP_FREE,
    CAP_PRE,
    CAP_POST,
    CAP_HALT
  } cap_state_t;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_single,
  input  logic              cmd_stop,
  input  logic              store_all,
  input  logic [POS_W-1:0]  trig_pos,
  input  logic              trig,
  input  logic              s_valid,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              capturing,
  output logic              done,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [ADDR_W-1:0] pre_cnt
);
  localparam int DEPTH = 1 << ADDR_W;

  cap_state_t        state;
  logic [ADDR_W-1:0] wptr;
  logic [ADDR_W:0]   seen;
  logic [ADDR_W-1:0] post_q;
  logic [ADDR_W-1:0] left;
  logic              all_q;

  // post-trigger length from the position: DEPTH*(512-q)/512, a shift
  logic [POS_W-1:0]        pos_eff;
  logic [POS_W:0]          span;
  logic [ADDR_W+POS_W:0]   prod;
  logic [ADDR_W-1:0]       post_len;
  logic [ADDR_W-1:0]       pre_limit;
  logic                    any_cmd;

  always_comb begin
    pos_eff  = (trig_pos == '0) ? POS_W'(1) : trig_pos;
    span     = (POS_W+1)'(POS_STEPS) - {1'b0, pos_eff};
    prod     = {span, {ADDR_W{1'b0}}};
    post_len = prod[POS_W +: ADDR_W];
    pre_limit = ADDR_W'(DEPTH - 1) - post_q;
  end

  assign capturing = (state == CAP_FREE) || (state == CAP_PRE) || (state == CAP_POST);
  assign any_cmd   = cmd_start || cmd_single || cmd_stop;
  assign wr_en     = capturing && !any_cmd && (all_q || s_valid);
  assign wr_addr   = wptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CAP_IDLE;
      wptr      <= '0;
      seen      <= '0;
      post_q    <= '0;
      left      <= '0;
      all_q     <= 1'b0;
      done      <= 1'b0;
      trig_addr <= '0;
      pre_cnt   <= '0;
    end else if (cmd_stop) begin
      if (capturing) begin
        state <= CAP_HALT;
        if (state == CAP_FREE) begin
          trig_addr <= wptr - ADDR_W'(1);
          if (seen == '0)
            pre_cnt <= '0;
          else if (seen[ADDR_W])
            pre_cnt <= ADDR_W'(DEPTH - 1);
          else
            pre_cnt <= seen[ADDR_W-1:0] - ADDR_W'(1);
        end
      end
    end else if (cmd_single || cmd_start) begin
      state     <= cmd_single ? CAP_PRE : CAP_FREE;
      wptr      <= '0;
      seen      <= '0;
      post_q    <= post_len;
      left      <= '0;
      all_q     <= store_all;
      done      <= 1'b0;
      trig_addr <= '0;
      pre_cnt   <= '0;
    end else if (wr_en) begin
      wptr <= wptr + ADDR_W'(1);
      unique case (state)
        CAP_FREE: begin
          if (!seen[ADDR_W]) seen <= seen + (ADDR_W+1)'(1);
        end
        CAP_PRE: begin
          if (trig) begin
            trig_addr <= wptr;
            pre_cnt   <= (seen > {1'b0, pre_limit}) ? pre_limit : seen[ADDR_W-1:0];
            if (post_q == '0) begin
              state <= CAP_HALT;
              done  <= 1'b1;
            end else begin
              state <= CAP_POST;
              left  <= post_q;
            end
          end else if (!seen[ADDR_W]) begin
            seen <= seen + (ADDR_W+1)'(1);
          end
        end
        CAP_POST: begin
          left <= left - ADDR_W'(1);
          if (left == ADDR_W'(1)) begin
            state <= CAP_HALT;
            done  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trace_ram.sv
module trace_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/trace_rdgate.sv
module trace_rdgate #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              capturing,
  input  logic [DATA_W-1:0] ram_q,
  output logic              ram_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  logic blocked_q;

  assign ram_rd = rd_en && !capturing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked_q <= 1'b0;
    else        blocked_q <= rd_en && capturing;
  end

  assign rd_err  = blocked_q;
  assign rd_data = blocked_q ? '0 : ram_q;
endmodule

// File: rtl/trace_buf.sv
module trace_buf
  import trace_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_single,
  input  logic              cmd_stop,
  input  logic              store_all,
  input  logic [POS_W-1:0]  trig_pos,
  input  logic              trig,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              done,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [ADDR_W-1:0] pre_cnt,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              ram_rd;
  logic [DATA_W-1:0] ram_q;

  trace_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_start(cmd_start), .cmd_single(cmd_single), .cmd_stop(cmd_stop),
    .store_all(store_all), .trig_pos(trig_pos), .trig(trig), .s_valid(s_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .capturing(s_ready), .done(done),
    .trig_addr(trig_addr), .pre_cnt(pre_cnt)
  );

  trace_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(s_data),
    .rd_en(ram_rd), .rd_addr(rd_addr), .rd_q(ram_q)
  );

  trace_rdgate #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .capturing(s_ready),
    .ram_q(ram_q), .ram_rd(ram_rd), .rd_data(rd_data), .rd_err(rd_err)
  );
endmodule

// File: rtl/trace_buf_chk.sv
module trace_buf_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_start,
  input logic              cmd_single,
  input logic              cmd_stop,
  input logic              s_ready,
  input logic              done,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_err
);
  // R2
  arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_single && !cmd_stop) |=> (s_ready && !done));

  // R2
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);

  // R2
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(s_ready));

  // R7
  rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && s_ready) |=> (rd_err && rd_data == '0));

  // R7
  rd_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !s_ready) |=> !rd_err);

  // R9
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> (!s_ready && !$rose(done)));

  // R8
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && !cmd_single && !cmd_stop) |=> (s_ready && !done));
endmodule

bind trace_buf trace_buf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_single(cmd_single),
  .cmd_stop(cmd_stop), .s_ready(s_ready), .done(done), .rd_en(rd_en),
  .rd_data(rd_data), .rd_err(rd_err)
);

// File: tb/sim_trace_buf.sv
`timescale 1ns/1ps
module sim_trace_buf;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 0, cmd_single = 0, cmd_stop = 0, store_all = 0;
  logic [8:0] trig_pos = '0;
  logic trig = 0, s_valid = 0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, done, rd_en = 0, rd_err;
  logic [AW-1:0] trig_addr, pre_cnt, rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  trace_buf #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_single(cmd_single),
    .cmd_stop(cmd_stop), .store_all(store_all), .trig_pos(trig_pos), .trig(trig),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .done(done),
    .trig_addr(trig_addr), .pre_cnt(pre_cnt), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, int a, int exp);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    chk(req, int'(rd_data), exp);
    chk(req, int'(rd_err), 0);
  endtask

  task automatic pulse(input bit st, input bit sg, input bit sp);
    cmd_start = st; cmd_single = sg; cmd_stop = sp;
    @(negedge clk);
    cmd_start = 0; cmd_single = 0; cmd_stop = 0;
  endtask

  // one triggered acquisition, then full readout
  task automatic acq(int p, int t, bit all);
    int pe = (p == 0) ? 1 : p;
    int post = (DEPTH * (512 - pe)) / 512;
    int pre_e = (t < DEPTH - 1 - post) ? t : DEPTH - 1 - post;
    int total = t + 1 + post;
    int n = 0;
    int cyc = 0;
    bit early = 0;
    trig_pos = 9'(p); store_all = all;
    pulse(0, 1, 0);
    trig_pos = '0;
    while (n < total) begin
      bit q = all ? 1'b1 : ((cyc % 3) != 1);
      s_valid = all ? cyc[0] : q;                 // R5: s_valid ignored when all
      s_data  = q ? DW'(n) : 8'hEE;
      trig    = (n == t);                          // R3: unqualified trigger ignored
      @(negedge clk);
      if (q) n++;
      cyc++;
      if (n < total && done) early = 1;
    end
    s_valid = 0; trig = 0;
    chk("R2 done not early", int'(early), 0);
    chk("R2 done", int'(done), 1);
    chk("R2 ready low", int'(s_ready), 0);
    chk("R3 trig_addr", int'(trig_addr), t % DEPTH);
    chk("R4 pre_cnt", int'(pre_cnt), pre_e);
    // R10: late samples and triggers must not land
    for (int k = 0; k < 3; k++) begin
      s_valid = 1; s_data = 8'hAA; trig = 1;
      @(negedge clk);
    end
    s_valid = 0; trig = 0;
    for (int k = -pre_e; k <= post; k++)
      rd_chk("R6 R10 readout", (t + k) % DEPTH, (t + k) & 8'hFF);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected 0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 done", int'(done), 0);
    chk("R1 s_ready", int'(s_ready), 0);
    chk("R1 rd_err", int'(rd_err), 0);
    rst_n = 1;
    @(negedge clk);

    // R7: read refused during capture
    store_all = 0;
    pulse(0, 1, 0);
    chk("R2 armed ready", int'(s_ready), 1);
    rd_en = 1; rd_addr = '0;
    @(negedge clk);
    rd_en = 0;
    chk("R7 blocked data", int'(rd_data), 0);
    chk("R7 blocked err", int'(rd_err), 1);
    // R9: stop during triggered acquisition
    s_valid = 1; s_data = 8'h11;
    @(negedge clk);
    s_valid = 0;
    pulse(0, 0, 1);
    chk("R9 abort ready", int'(s_ready), 0);
    chk("R9 abort done", int'(done), 0);
    rd_chk("R7 read after stop", 0, 8'h11);

    // sweep every trigger position
    for (int p = 0; p < 512; p++)
      acq(p, (p * 7) % 45, p[0]);

    // R8: free recording wraps, trigger ignored
    store_all = 1;
    pulse(1, 0, 0);
    for (int n = 0; n < 40; n++) begin
      s_data = DW'(n); trig = (n == 3);
      @(negedge clk);
    end
    trig = 0;
    chk("R8 still recording", int'(s_ready), 1);
    chk("R8 no done", int'(done), 0);
    pulse(0, 0, 1);
    chk("R8 halted", int'(s_ready), 0);
    chk("R8 done low", int'(done), 0);
    chk("R8 last addr", int'(trig_addr), 7);
    chk("R8 pre full", int'(pre_cnt), 31);
    rd_chk("R8 newest", 7, 39);
    rd_chk("R8 oldest", 8, 8);

    pulse(1, 0, 0);
    for (int n = 0; n < 5; n++) begin
      s_data = DW'(100 + n);
      @(negedge clk);
    end
    pulse(0, 0, 1);
    chk("R8 short addr", int'(trig_addr), 4);
    chk("R8 short pre", int'(pre_cnt), 4);
    rd_chk("R6 first sample", 0, 100);

    // R9: stop beats single
    pulse(0, 1, 1);
    chk("R9 stop wins", int'(s_ready), 0);
    // R9: single beats start (trigger honoured, pos 511 -> post 0)
    trig_pos = 9'd511;
    pulse(1, 1, 0);
    s_data = 8'h5A; trig = 1;
    @(negedge clk);
    trig = 0;
    chk("R9 single wins done", int'(done), 1);
    chk("R2 post zero addr", int'(trig_addr), 0);
    store_all = 0;

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule